// File: doc/BRIEF.md
# Power-up port option loader

This block sits between reset and the processor core. When the active-low reset is released, it reads 256 option bytes from the reserved page at the top of program memory. It reads one byte per cycle in rising address order. It turns the first six of those bytes into a configuration for every port pin: whether the pin drives as a push-pull (CMOS) output or as an N-channel open-drain output, and whether its pull-up is enabled. It also holds the core in a stopped state for a start-up window of fixed length. The window is counted in timer ticks, and its length in ticks is derived from a clock-rate parameter (kHz) and a window-length parameter (microseconds); the defaults give 3 ms.

When the window has expired and every byte has been captured, the decoded configuration is loaded into the output registers in a single cycle. In that same cycle the run-enable output rises, and the core starts fetching at address 0000H. Until then every pin is reported as open drain with no pull-up, so no pad drives or pulls before its option is known. The memory array, the pad cells and the program that builds the option page are not part of this block.

Top module: `opt_loader`

## Requirements
- R1: After reset release the block issues exactly 256 reads on consecutive cycles, with addresses FF00H, FF01H, ... FFFFH in rising order. The first read is in the first cycle after the first clock edge following release. No read is issued once cpu_run_o is high. Read data is taken one cycle after the read strobe.
- R2: Let WIN = CLK_KHZ*WIN_US/1000. cpu_run_o is low during reset. It rises on the clock edge at which the count of tick_i-high edges since reset release has reached WIN. Once high, it stays high until reset.
- R3: While cpu_run_o is low, every form output and every pull-up output is 0. A form bit of 0 means open drain.
- R4: Option byte offsets and form encoding. Offset 00H bit i gives the form of port 0 pin i. Offset 02H bit i gives the form of port 1 pin i. Offset 04H bits 3:0 give the form of port 3 pins 3:0. A bit value of 1 means CMOS and 0 means open drain. Bytes at offsets 06H to FFH have no effect.
- R5: Port 0 pull-ups are set per nibble. Bit 0 of offset 01H enables pins 3:0, and bit 1 of offset 01H enables pins 7:4.
- R6: Pull-ups of the other ports are set per bit. Offset 03H bit i controls port 1 pin i. Offset 04H bit 4+i controls port 3 pin i. Offset 05H bit i controls port 7 pin i, for i from 0 to 3.
- R7: A pin whose form is open drain has its pull-up output at 0, whatever its pull-up option bit holds.
- R8: Port 7 pins 4 and 5 have no pull-up option. Their pull-up outputs are always 0.
- R9: While cpu_run_o stays high, no configuration output changes.
- R10: Asserting reset while the bytes are being read returns all outputs to the safe state. The next release restarts the reads at FF00H, and the configuration then reflects the newly read page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timer tick; each high cycle advances the start-up window |
| mem_addr_o | output | 16 | Program memory read address |
| mem_rd_o | output | 1 | Read strobe |
| mem_data_i | input | 8 | Read data, valid the cycle after the strobe |
| p0_cmos_o | output | 8 | Port 0 form per pin (1 = CMOS) |
| p0_pu_o | output | 8 | Port 0 pull-up enable per pin |
| p1_cmos_o | output | 8 | Port 1 form per pin |
| p1_pu_o | output | 8 | Port 1 pull-up enable per pin |
| p3_cmos_o | output | 4 | Port 3 form per pin |
| p3_pu_o | output | 4 | Port 3 pull-up enable per pin |
| p7_pu_o | output | 6 | Port 7 pull-up enable per pin |
| cpu_run_o | output | 1 | Core run enable; fetch begins at 0000H when it rises |

## Verification
The assertions check several properties on every cycle:
- the safe all-zero configuration while the core is held;
- no pull-up on an open-drain pin, and none on port 7 pins 4 and 5;
- that run-enable never falls and the configuration never moves once running;
- that reads step up by one address and stop after the page.

Only the bench scenarios can show the following:
- that each option bit reaches the right pin, including the nibble grouping of port 0;
- that the bytes beyond the sixth are ignored;
- that run-enable rises on exactly the edge after the last window tick, also when ticks are sparse;
- that a reset in the middle of loading restarts from FF00H with the new page.

// File: rtl/opt_pkg.sv
package opt_pkg;
  localparam int ADDR_W    = 16;
  localparam int BYTE_W    = 8;
  localparam int OPT_BASE  = 16'hFF00;
  localparam int OPT_BYTES = 256;

  // Byte offsets inside the option page that the decoder reads
  localparam int OFS_P0_FORM = 0;
  localparam int OFS_P0_PU   = 1;
  localparam int OFS_P1_FORM = 2;
  localparam int OFS_P1_PU   = 3;
  localparam int OFS_P3      = 4;
  localparam int OFS_P7_PU   = 5;
  localparam int NUM_USED    = 6;

  localparam int P0_W    = 8;
  localparam int P1_W    = 8;
  localparam int P3_W    = 4;
  localparam int P7_W    = 6;
  localparam int P7_PU_W = 4;  // pins with a pull-up option
  localparam int NIB_W   = 4;

  typedef struct packed {
    logic [P0_W-1:0] p0_cmos;
    logic [P0_W-1:0] p0_pu;
    logic [P1_W-1:0] p1_cmos;
    logic [P1_W-1:0] p1_pu;
    logic [P3_W-1:0] p3_cmos;
    logic [P3_W-1:0] p3_pu;
    logic [P7_W-1:0] p7_pu;
  } port_cfg_t;

  typedef enum logic {ST_LOAD = 1'b0, ST_RUN = 1'b1} ld_state_e;
endpackage

// File: rtl/opt_fetch.sv
module opt_fetch import opt_pkg::*; #(
  parameter int NBYTES = OPT_BYTES,
  parameter int BASE   = OPT_BASE
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  output logic                      mem_rd_o,
  output logic [ADDR_W-1:0]         mem_addr_o,
  output logic                      cap_vld_o,
  output logic [$clog2(NBYTES)-1:0] cap_idx_o,
  output logic                      done_o
);
  localparam int IDX_W = $clog2(NBYTES);
  localparam int CNT_W = IDX_W + 1;

  logic             go_q, go_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             vld_q, vld_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;

  assign mem_rd_o   = go_q && (cnt_q < CNT_W'(NBYTES));
  assign mem_addr_o = ADDR_W'(BASE) + ADDR_W'(cnt_q[IDX_W-1:0]);

  always_comb begin
    go_d   = 1'b1;
    cnt_d  = cnt_q;
    if (mem_rd_o) cnt_d = cnt_q + CNT_W'(1);
    vld_d  = mem_rd_o;
    idx_d  = cnt_q[IDX_W-1:0];
    done_d = done_q || (vld_q && (idx_q == IDX_W'(NBYTES - 1)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_q   <= 1'b0;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      go_q   <= go_d;
      cnt_q  <= cnt_d;
      vld_q  <= vld_d;
      idx_q  <= idx_d;
      done_q <= done_d;
    end
  end

  assign cap_vld_o = vld_q;
  assign cap_idx_o = idx_q;
  assign done_o    = done_q;

  AST_RD_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && $past(mem_rd_o)) |-> (mem_addr_o == $past(mem_addr_o) + ADDR_W'(1))); // R1
  AST_RD_BEFORE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_rd_o); // R1
endmodule

// File: rtl/opt_window.sv
module opt_window #(
  parameter int WIN_TICKS = 18000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic done_o
);
  localparam int CW = $clog2(WIN_TICKS + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done_o = (cnt_q == CW'(WIN_TICKS));
  assign cnt_en = tick_i && !done_o;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  AST_WIN_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o); // R2
endmodule

// File: rtl/opt_decode.sv
module opt_decode import opt_pkg::*; #(
  parameter int IDX_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_vld_i,
  input  logic [IDX_W-1:0]  cap_idx_i,
  input  logic [BYTE_W-1:0] cap_data_i,
  output port_cfg_t         cfg_o
);
  logic [NUM_USED-1:0][BYTE_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    for (int k = 0; k < NUM_USED; k++) begin
      if (cap_vld_i && (cap_idx_i == IDX_W'(k))) sh_d[k] = cap_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  logic [P0_W-1:0] p0_pu;
  logic [P1_W-1:0] p1_pu;
  logic [P3_W-1:0] p3_pu;
  logic [P7_W-1:0] p7_pu;

  // Open-drain pins never pull up: each enable is gated by its form bit.
  for (genvar i = 0; i < P0_W; i++) begin : g_p0
    assign p0_pu[i] = sh_q[OFS_P0_PU][i / NIB_W] & sh_q[OFS_P0_FORM][i];
  end
  for (genvar i = 0; i < P1_W; i++) begin : g_p1
    assign p1_pu[i] = sh_q[OFS_P1_PU][i] & sh_q[OFS_P1_FORM][i];
  end
  for (genvar i = 0; i < P3_W; i++) begin : g_p3
    assign p3_pu[i] = sh_q[OFS_P3][P3_W + i] & sh_q[OFS_P3][i];
  end
  for (genvar i = 0; i < P7_W; i++) begin : g_p7
    if (i < P7_PU_W) begin : g_opt
      assign p7_pu[i] = sh_q[OFS_P7_PU][i];
    end else begin : g_none
      assign p7_pu[i] = 1'b0;
    end
  end

  logic unused_bits;
  assign unused_bits = &{sh_q[OFS_P0_PU][BYTE_W-1:2], sh_q[OFS_P7_PU][BYTE_W-1:P7_PU_W]};

  always_comb begin
    cfg_o         = '0;
    cfg_o.p0_cmos = sh_q[OFS_P0_FORM];
    cfg_o.p0_pu   = p0_pu;
    cfg_o.p1_cmos = sh_q[OFS_P1_FORM];
    cfg_o.p1_pu   = p1_pu;
    cfg_o.p3_cmos = sh_q[OFS_P3][P3_W-1:0];
    cfg_o.p3_pu   = p3_pu;
    cfg_o.p7_pu   = p7_pu;
  end
endmodule

// File: rtl/opt_loader.sv
module opt_loader import opt_pkg::*; #(
  parameter int CLK_KHZ = 6000,
  parameter int WIN_US  = 3000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [BYTE_W-1:0] mem_data_i,
  output logic [P0_W-1:0]   p0_cmos_o,
  output logic [P0_W-1:0]   p0_pu_o,
  output logic [P1_W-1:0]   p1_cmos_o,
  output logic [P1_W-1:0]   p1_pu_o,
  output logic [P3_W-1:0]   p3_cmos_o,
  output logic [P3_W-1:0]   p3_pu_o,
  output logic [P7_W-1:0]   p7_pu_o,
  output logic              cpu_run_o
);
  localparam int WIN_TICKS = CLK_KHZ * WIN_US / 1000;
  localparam int IDX_W     = $clog2(OPT_BYTES);

  logic             cap_vld, fetch_done, win_done;
  logic [IDX_W-1:0] cap_idx;
  port_cfg_t        dec_cfg;

  opt_fetch #(.NBYTES(OPT_BYTES), .BASE(OPT_BASE)) u_fetch (
    .clk_i(clk_i), .rst_ni(rst_ni), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
    .cap_vld_o(cap_vld), .cap_idx_o(cap_idx), .done_o(fetch_done));

  opt_window #(.WIN_TICKS(WIN_TICKS)) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .done_o(win_done));

  opt_decode #(.IDX_W(IDX_W)) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_vld_i(cap_vld), .cap_idx_i(cap_idx),
    .cap_data_i(mem_data_i), .cfg_o(dec_cfg));

  ld_state_e state_q, state_d;
  port_cfg_t cfg_q, cfg_d;
  logic      release_en;

  assign release_en = (state_q == ST_LOAD) && fetch_done && win_done;

  always_comb begin
    state_d = state_q;
    cfg_d   = cfg_q;
    if (release_en) begin
      state_d = ST_RUN;
      cfg_d   = dec_cfg;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOAD;
      cfg_q   <= '0;
    end else begin
      state_q <= state_d;
      cfg_q   <= cfg_d;
    end
  end

  assign cpu_run_o = (state_q == ST_RUN);
  assign p0_cmos_o = cfg_q.p0_cmos;
  assign p0_pu_o   = cfg_q.p0_pu;
  assign p1_cmos_o = cfg_q.p1_cmos;
  assign p1_pu_o   = cfg_q.p1_pu;
  assign p3_cmos_o = cfg_q.p3_cmos;
  assign p3_pu_o   = cfg_q.p3_pu;
  assign p7_pu_o   = cfg_q.p7_pu;

  AST_SAFE_WHILE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_run_o |-> (cfg_q == '0)); // R3
  AST_OD_NO_PULLUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((p0_pu_o & ~p0_cmos_o) == '0) && ((p1_pu_o & ~p1_cmos_o) == '0)
    && ((p3_pu_o & ~p3_cmos_o) == '0)); // R7
  AST_P7_UPPER_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p7_pu_o[P7_W-1:P7_PU_W] == '0); // R8
  AST_RUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_run_o |=> cpu_run_o); // R2
  AST_RUN_AFTER_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_run_o) |-> $past(win_done) && $past(fetch_done)); // R2
  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_run_o && $past(cpu_run_o)) |-> $stable(cfg_q)); // R9
  AST_NO_READ_RUNNING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_run_o |-> !mem_rd_o); // R1
endmodule

// File: tb/tb_opt_loader.sv
module tb_opt_loader;
  import opt_pkg::*;

  localparam int CLK_KHZ = 250000;
  localparam int WIN_US  = 2;
  localparam int WIN     = CLK_KHZ * WIN_US / 1000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b1;
  logic [ADDR_W-1:0] addr;
  logic              rd;
  logic [BYTE_W-1:0] rdata = '0;
  logic [7:0]        p0c, p0p, p1c, p1p;
  logic [3:0]        p3c, p3p;
  logic [5:0]        p7p;
  logic              run;

  int checks = 0;
  int errors = 0;
  logic [7:0] img [256];
  port_cfg_t  expq [$];
  port_cfg_t  cur_exp;
  bit         stall = 1'b0;
  int         phase = 0;

  always #2 clk = ~clk;

  opt_loader #(.CLK_KHZ(CLK_KHZ), .WIN_US(WIN_US)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .mem_addr_o(addr), .mem_rd_o(rd),
    .mem_data_i(rdata), .p0_cmos_o(p0c), .p0_pu_o(p0p), .p1_cmos_o(p1c), .p1_pu_o(p1p),
    .p3_cmos_o(p3c), .p3_pu_o(p3p), .p7_pu_o(p7p), .cpu_run_o(run));

  // program memory model: one cycle read latency
  always @(posedge clk) begin
    if (rd) rdata <= (addr[15:8] == 8'hFF) ? img[addr[7:0]] : 8'h00;
  end

  // tick source: every cycle, or one in three when stalling
  always @(negedge clk) begin
    phase = (phase == 2) ? 0 : phase + 1;
    tick <= stall ? (phase == 0) : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic port_cfg_t expect_cfg();
    port_cfg_t e;
    e = '0;
    e.p0_cmos = img[0];                                  // R4
    for (int i = 0; i < 8; i++)
      e.p0_pu[i] = img[1][i / 4] & img[0][i];            // R5 R7
    e.p1_cmos = img[2];
    e.p1_pu   = img[3] & img[2];                         // R6 R7
    e.p3_cmos = img[4][3:0];
    e.p3_pu   = img[4][7:4] & img[4][3:0];
    e.p7_pu   = {2'b00, img[5][3:0]};                    // R8
    return e;
  endfunction

  function automatic port_cfg_t seen_cfg();
    port_cfg_t s;
    s.p0_cmos = p0c; s.p0_pu = p0p; s.p1_cmos = p1c; s.p1_pu = p1p;
    s.p3_cmos = p3c; s.p3_pu = p3p; s.p7_pu = p7p;
    return s;
  endfunction

  task automatic fill(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                      input logic [7:0] b3, input logic [7:0] b4, input logic [7:0] b5,
                      input logic [7:0] rest);
    img[0] = b0; img[1] = b1; img[2] = b2; img[3] = b3; img[4] = b4; img[5] = b5;
    for (int k = 6; k < 256; k++) img[k] = rest ^ 8'(k);
  endtask

  // driver: pushes the expected configuration, then resets and waits for release
  task automatic run_case(input bit slow);
    expq.push_back(expect_cfg());
    @(negedge clk); stall = slow; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    while (!run) @(negedge clk);
    repeat (20) @(negedge clk);
  endtask

  // monitor
  int tk = 0;
  int rd_idx = 0;
  bit prev_run = 1'b0;
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      tk = 0; rd_idx = 0; prev_run = 1'b0;
      chk(!run && !rd, "R2 held in reset", {62'd0, run, rd}, 64'd0);
      chk(seen_cfg() == '0, "R3 safe in reset", 64'(seen_cfg()), 64'd0);
    end else begin
      int tk_prev;
      tk_prev = tk;
      tk += int'(tick);
      chk(run == (tk_prev >= WIN), "R2 release edge", 64'(run), 64'(tk_prev >= WIN));
      if (!run) chk(seen_cfg() == '0, "R3 safe while held", 64'(seen_cfg()), 64'd0);
      if (rd) begin
        chk(addr == 16'hFF00 + 16'(rd_idx), "R1 read address", 64'(addr), 64'(16'hFF00 + 16'(rd_idx)));
        rd_idx++;
        chk(!run && rd_idx <= 256, "R1 read count", 64'(rd_idx), 64'd256);
      end else if (rd_idx > 0 && rd_idx < 256) begin
        chk(1'b0, "R1 reads back to back", 64'(rd_idx), 64'd256);
      end
      if (run && !prev_run) begin
        chk(rd_idx == 256, "R1 all bytes read", 64'(rd_idx), 64'd256);
        if (expq.size() == 0) chk(1'b0, "R4 scoreboard empty", 64'd0, 64'd1);
        else begin
          cur_exp = expq.pop_front();
          chk(p0c == cur_exp.p0_cmos && p1c == cur_exp.p1_cmos && p3c == cur_exp.p3_cmos,
              "R4 forms", {40'd0, p0c, p1c, p3c, 4'd0}, {40'd0, cur_exp.p0_cmos, cur_exp.p1_cmos, cur_exp.p3_cmos, 4'd0});
          chk(p0p == cur_exp.p0_pu, "R5 port0 pull-up nibbles", 64'(p0p), 64'(cur_exp.p0_pu));
          chk(p1p == cur_exp.p1_pu && p3p == cur_exp.p3_pu && p7p[3:0] == cur_exp.p7_pu[3:0],
              "R6 R7 per-bit pull-ups", {46'd0, p1p, p3p, p7p[3:0]}, {46'd0, cur_exp.p1_pu, cur_exp.p3_pu, cur_exp.p7_pu[3:0]});
          chk(p7p[5:4] == 2'b00, "R8 port7 upper pins", 64'(p7p[5:4]), 64'd0);
        end
      end else if (run) begin
        chk(seen_cfg() == cur_exp, "R9 frozen while running", 64'(seen_cfg()), 64'(cur_exp));
      end
      prev_run = run;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    fill(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    repeat (4) @(negedge clk);
    // all erased: everything CMOS, all options on, P74/P75 still off (R8)
    fill(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    run_case(1'b0);
    // all open drain, other bytes noisy (R4 ignored bytes)
    fill(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h5A);
    run_case(1'b0);
    // open drain masks pull-ups (R7), low nibble pull-up only (R5)
    fill(8'hA5, 8'h01, 8'h3C, 8'hF0, 8'hF6, 8'h09, 8'hC3);
    run_case(1'b0);
    // high nibble pull-up only (R5), sparse ticks lengthen the window (R2)
    fill(8'hF0, 8'h02, 8'hFF, 8'h81, 8'h5F, 8'hF6, 8'h11);
    run_case(1'b1);
    // R10: reset in the middle of loading, then a different page
    fill(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    @(negedge clk); stall = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (120) @(negedge clk);
    chk(!run, "R10 still held mid-load", 64'(run), 64'd0);
    fill(8'h0F, 8'h03, 8'h55, 8'hFF, 8'h3A, 8'h06, 8'h77);
    run_case(1'b0);
    chk(expq.size() == 0, "R10 scoreboard drained", 64'(expq.size()), 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule